// File: doc/BRIEF.md
# Serial ADC Power-Mode Tracker

This block is a synthesizable device-side model of the digital interface of a low-power serial converter. It oversamples chip-select and the serial clock on a faster system clock and follows the converter's power state. The power state is either powered down or normal. The block also follows the track/hold state and the elapsed power-up time. A frame that starts while the converter is asleep begins waking it. How the frame ends decides the next mode: if chip-select returns high too early, the converter goes back to sleep. This also rejects glitches and short clock bursts.

Each frame shifts out a 16-bit word on the serial data output. The word is four zero bits followed by a 12-bit sample taken from an input port, most significant bit first. The block also reports whether the frame carries a valid sample, meaning the power-up time had elapsed before the frame began. It flags a frame that started too soon after the previous one ended, which breaks the quiet-time rule. All timing limits are parameters counted in system clocks.

Top module: `adc_mode_tracker`

## Requirements
- R1: While reset is held and just after its release, `powered` equals `bootPowered`, `trackMode` is 1, and `sdoEn`, `sdo`, `frameValid` and `quietViol` are 0.
- R2: When chip-select returns high after fewer than WAKE_EDGES (10) serial-clock falling edges in the frame, the model ends in power-down (`powered`=0). This includes a frame with no clock edges and a burst of 8 edges.
- R3: When chip-select returns high after WAKE_EDGES or more falling edges, the model ends in normal mode (`powered`=1).
- R4: Entering power-down sets `trackMode` to 0. In a frame that starts while powered down, `trackMode` stays 0 until the first serial-clock edge of that frame and is 1 from then on.
- R5: `frameValid` is 1 during a frame only if at least PWRUP_CYC system clocks passed between the start of power-up and the chip-select falling edge, with no power-down in between. Power-up starts at a chip-select fall in power-down, or at reset release when `bootPowered`=1. `frameValid` is 0 between frames.
- R6: `quietViol` is 1 during a frame whose chip-select falling edge came no more than QUIET_CYC system clocks after the previous rising edge. It is 0 otherwise and between frames.
- R7: `sdoEn` is 1 exactly while synchronized chip-select is low, and `sdo` is 0 whenever `sdoEn` is 0.
- R8: After k serial-clock falling edges of a frame, `sdo` carries bit 15-k of the word {4'b0000, sample}, with bit 15 (a zero) shown before any edge. Once all 16 bits have gone out, `sdo` is 0.
- R9: The sample is captured at the chip-select falling edge. Changes on `sampleIn` later in the frame do not alter the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rstN | input | 1 | Active-low reset; models supply application |
| bootPowered | input | 1 | Mode taken at reset: 1 normal, 0 power-down |
| csN | input | 1 | Chip-select from the host, active low |
| sclk | input | 1 | Serial clock from the host, idles high |
| sampleIn | input | 12 | Sample word to be returned in the next frame |
| sdo | output | 1 | Serial data bit |
| sdoEn | output | 1 | Output driver enable; low means the data line floats |
| powered | output | 1 | 1 in normal mode, 0 in power-down |
| trackMode | output | 1 | 1 while the track/hold tracks, 0 while it holds |
| frameValid | output | 1 | The current frame carries a valid sample |
| quietViol | output | 1 | The current frame broke the quiet-time rule |

## Verification
A fall counter that miscounts or saturates wrongly shows up in `powered` within a few system clocks of the chip-select rise that ends the frame. Frames with 8, 9, 10 and more edges separate an off-by-one error from a correct count. A power-up timer that starts or clears at the wrong time only shows in `frameValid` at the start of the next frame. The bench therefore places frames well clear of the PWRUP_CYC boundary and checks both sides of it. A shifter fault appears at the first falling edge that exposes the bad bit, so every bit of every frame is compared.

// File: rtl/adcmt_pkg.sv
package adcmt_pkg;
  // synchronized pin events seen by the control
  typedef struct packed {
    logic csFall;
    logic csRise;
    logic csLow;
    logic sclkFall;
    logic sclkEdge;
  } pinEvT;

  // strobes from control to the shift datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic clear;
  } shiftCtlT;
endpackage

// File: rtl/adcmt_data.sv
module adcmt_data
  import adcmt_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int FRAME_BITS = 16,
  parameter int SYNC_STG   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                sclk,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  shiftCtlT            ctl,
  output pinEvT               ev,
  output logic                sdo,
  output logic                sdoEn
);
  localparam int PAD = FRAME_BITS - SAMPLE_W;
  localparam int TOP = FRAME_BITS - 1;

  logic [SYNC_STG-1:0]   csSync, sclkSync;
  logic                  csPrev, sclkPrev;
  logic [FRAME_BITS-1:0] shiftReg;

  // both pins rest high, so the synchronizers reset to ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= '1;
      sclkSync <= '1;
      csPrev   <= 1'b1;
      sclkPrev <= 1'b1;
    end else begin
      csSync   <= {csSync[SYNC_STG-2:0], csN};
      sclkSync <= {sclkSync[SYNC_STG-2:0], sclk};
      csPrev   <= csSync[SYNC_STG-1];
      sclkPrev <= sclkSync[SYNC_STG-1];
    end
  end

  always_comb begin
    ev.csFall   = csPrev & ~csSync[SYNC_STG-1];
    ev.csRise   = ~csPrev & csSync[SYNC_STG-1];
    ev.csLow    = ~csSync[SYNC_STG-1];
    ev.sclkFall = sclkPrev & ~sclkSync[SYNC_STG-1];
    ev.sclkEdge = sclkPrev ^ sclkSync[SYNC_STG-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.clear) begin
      shiftReg <= '0;
    end else if (ctl.load) begin
      shiftReg <= {{PAD{1'b0}}, sampleIn};
    end else if (ctl.shift) begin
      shiftReg <= {shiftReg[TOP-1:0], 1'b0};
    end
  end

  assign sdoEn = ev.csLow;
  assign sdo   = ev.csLow & shiftReg[TOP];

  // the freshly loaded word always leads with a padding zero
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> !shiftReg[TOP]); // R8
endmodule

// File: rtl/adcmt_ctrl.sv
module adcmt_ctrl
  import adcmt_pkg::*;
#(
  parameter int WAKE_EDGES = 10,
  parameter int PWRUP_CYC  = 100,
  parameter int QUIET_CYC  = 6
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     bootPowered,
  input  pinEvT    ev,
  output shiftCtlT ctl,
  output logic     modeOn,
  output logic     track,
  output logic     frameValid,
  output logic     quietViol
);
  localparam int FW = $clog2(WAKE_EDGES + 1);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int QW = $clog2(QUIET_CYC + 1);
  localparam logic [FW-1:0] FALL_MAX = FW'(WAKE_EDGES);
  localparam logic [PW-1:0] PWR_LAST = PW'(PWRUP_CYC - 1);
  localparam logic [QW-1:0] QUIET_MAX = QW'(QUIET_CYC);

  logic [FW-1:0] fallCnt;
  logic [PW-1:0] pwrCnt;
  logic [QW-1:0] quietCnt;
  logic          warming, awake;

  always_comb begin
    ctl.load  = ev.csFall;
    ctl.shift = ev.sclkFall & ev.csLow;
    ctl.clear = ev.csRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeOn     <= bootPowered;
      track      <= 1'b1;
      fallCnt    <= '0;
      warming    <= bootPowered;
      awake      <= 1'b0;
      pwrCnt     <= '0;
      frameValid <= 1'b0;
      quietViol  <= 1'b0;
      quietCnt   <= QUIET_MAX;
    end else begin
      // power-up timer
      if (warming && !awake) begin
        if (pwrCnt == PWR_LAST) awake <= 1'b1;
        else                    pwrCnt <= pwrCnt + 1'b1;
      end
      // quiet-time counter since the last frame end
      if (quietCnt < QUIET_MAX) quietCnt <= quietCnt + 1'b1;
      // leave hold on the first clock edge of a frame
      if (ev.csLow && ev.sclkEdge) track <= 1'b1;

      if (ev.csFall) begin
        fallCnt    <= '0;
        frameValid <= awake;
        quietViol  <= (quietCnt < QUIET_MAX);
        if (!modeOn && !warming) begin
          warming <= 1'b1;
          pwrCnt  <= '0;
        end
      end else if (ctl.shift && fallCnt < FALL_MAX) begin
        fallCnt <= fallCnt + 1'b1;
      end

      if (ev.csRise) begin
        frameValid <= 1'b0;
        quietViol  <= 1'b0;
        quietCnt   <= '0;
        if (fallCnt >= FALL_MAX) begin
          modeOn <= 1'b1;
        end else begin
          modeOn  <= 1'b0;
          track   <= 1'b0;
          warming <= 1'b0;
          awake   <= 1'b0;
          pwrCnt  <= '0;
        end
      end
    end
  end

  AST_MODE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    !ev.csRise |=> $stable(modeOn)); // R2
  AST_FALL_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    fallCnt <= FALL_MAX); // R3
  AST_NORMAL_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    modeOn |-> track); // R4
  AST_VALID_ONLY_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> modeOn); // R5
  AST_QUIET_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    quietViol |-> (ev.csLow || ev.csRise)); // R6
endmodule

// File: rtl/adc_mode_tracker.sv
module adc_mode_tracker
  import adcmt_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int FRAME_BITS = 16,
  parameter int WAKE_EDGES = 10,
  parameter int PWRUP_CYC  = 100,
  parameter int QUIET_CYC  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bootPowered,
  input  logic                csN,
  input  logic                sclk,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic                sdo,
  output logic                sdoEn,
  output logic                powered,
  output logic                trackMode,
  output logic                frameValid,
  output logic                quietViol
);
  pinEvT    ev;
  shiftCtlT ctl;

  adcmt_data #(
    .SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS), .SYNC_STG(2)
  ) u_data (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sampleIn(sampleIn),
    .ctl(ctl), .ev(ev), .sdo(sdo), .sdoEn(sdoEn)
  );

  adcmt_ctrl #(
    .WAKE_EDGES(WAKE_EDGES), .PWRUP_CYC(PWRUP_CYC), .QUIET_CYC(QUIET_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bootPowered(bootPowered), .ev(ev), .ctl(ctl),
    .modeOn(powered), .track(trackMode), .frameValid(frameValid),
    .quietViol(quietViol)
  );

  AST_DATA_FLOATS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> !sdo); // R7
endmodule

// File: tb/adc_mode_tracker_bench.sv
module adc_mode_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PWRUP = 60;
  localparam int QUIET = 16;
  localparam int WAKE  = 10;
  localparam int HALF  = 4;
  localparam int MARGIN = 5;

  logic clk = 1'b0, rstN = 1'b0, bootPowered = 1'b0, csN = 1'b1, sclk = 1'b1;
  logic [11:0] sampleIn = '0;
  logic sdo, sdoEn, powered, trackMode, frameValid, quietViol;

  int checks = 0, errors = 0, cyc = 0;
  logic expMode, expTrack, warmActive;
  int warmStart, lastRise;

  adc_mode_tracker #(.PWRUP_CYC(PWRUP), .QUIET_CYC(QUIET), .WAKE_EDGES(WAKE)) u_adc_mode_tracker (
    .clk(clk), .rstN(rstN), .bootPowered(bootPowered), .csN(csN), .sclk(sclk),
    .sampleIn(sampleIn), .sdo(sdo), .sdoEn(sdoEn), .powered(powered),
    .trackMode(trackMode), .frameValid(frameValid), .quietViol(quietViol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic wordBit(logic [11:0] w, int idx);
    logic [15:0] full = {4'b0000, w};
    return (idx >= 0 && idx <= 15) ? full[idx] : 1'b0;
  endfunction

  task automatic doReset(logic boot);
    rstN = 1'b0; csN = 1'b1; sclk = 1'b1; bootPowered = boot;
    tick(3);
    chk(powered == boot, "R1 powered in reset", powered, boot);
    rstN = 1'b1;
    expMode = boot; expTrack = 1'b1; warmActive = boot; warmStart = cyc;
    lastRise = -100000;
    tick(2);
    chk(powered == boot, "R1 powered", powered, boot);
    chk(trackMode == 1'b1, "R1 track", trackMode, 1);
    chk(!sdoEn && !sdo, "R1 sdo idle", {sdoEn, sdo}, 0);
    chk(!frameValid && !quietViol, "R1 flags", {frameValid, quietViol}, 0);
  endtask

  // gap counts system clocks from the previous chip-select rise (>= 8)
  task automatic runFrame(int nFalls, int gap, logic [11:0] word);
    int t, el, bitIdx;
    logic expViol, expVal, valKnown;
    if (gap > 5) tick(gap - 5);
    sampleIn = word;
    csN = 1'b0;
    t = cyc;
    expViol = (t - lastRise) <= QUIET;
    el = t - warmStart;
    valKnown = !warmActive || el >= PWRUP + MARGIN || el <= PWRUP - MARGIN;
    expVal = warmActive && el >= PWRUP;
    if (!expMode && !warmActive) begin
      warmActive = 1'b1; warmStart = t;
    end
    tick(6);
    sampleIn = ~word; // R9: later changes must not reach the frame
    chk(sdoEn == 1'b1, "R7 enable in frame", sdoEn, 1);
    chk(quietViol == expViol, "R6 quiet flag", quietViol, expViol);
    if (valKnown) chk(frameValid == expVal, "R5 valid flag", frameValid, expVal);
    chk(trackMode == expTrack, "R4 track before edge", trackMode, expTrack);
    chk(sdo == 1'b0, "R8 leading zero", sdo, 0);
    for (int i = 0; i < nFalls; i++) begin
      sclk = 1'b0;
      tick(HALF);
      expTrack = 1'b1;
      bitIdx = 15 - (i + 1);
      chk(sdo == wordBit(word, bitIdx), "R8 R9 data bit", sdo, wordBit(word, bitIdx));
      chk(trackMode == 1'b1, "R4 track after edge", trackMode, 1);
      sclk = 1'b1;
      tick(HALF);
    end
    csN = 1'b1;
    lastRise = cyc;
    if (nFalls < WAKE) begin
      expMode = 1'b0; expTrack = 1'b0; warmActive = 1'b0;
    end else begin
      expMode = 1'b1;
    end
    tick(5);
    chk(!sdoEn && !sdo, "R7 idle after frame", {sdoEn, sdo}, 0);
    chk(powered == expMode, nFalls < WAKE ? "R2 power-down" : "R3 normal", powered, expMode);
    chk(trackMode == expTrack, "R4 track after frame", trackMode, expTrack);
    chk(!frameValid && !quietViol, "R5 R6 cleared", {frameValid, quietViol}, 0);
  endtask

  initial begin
    int n, g;
    void'($urandom(32'd1357));
    // boot in power-down
    doReset(1'b0);
    runFrame(8, 40, 12'hA5C);   // R2 eight-edge burst stays down
    runFrame(0, 40, 12'h000);   // R2 glitch
    runFrame(9, 40, 12'h3C1);   // R2 one short of the limit
    runFrame(10, 40, 12'hFFF);  // R3 wake, R4 hold then track
    runFrame(16, 10, 12'h801);  // R6 violation, R5 valid
    runFrame(16, 30, 12'h7FE);  // R8 full word
    runFrame(5, 30, 12'h155);   // R4 back to hold
    runFrame(12, 30, 12'h2AA);  // R4 wake again, R5 invalid
    // boot in normal mode: first frame precedes power-up time
    doReset(1'b1);
    runFrame(16, 8, 12'h9C3);   // R5 invalid though powered
    runFrame(16, 40, 12'h4B7);  // R5 valid
    for (int k = 0; k < 40; k++) begin
      n = $urandom_range(0, 16);
      g = ($urandom_range(0, 1) == 1) ? $urandom_range(8, 12) : $urandom_range(20, 90);
      runFrame(n, g, 12'($urandom()));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule